// File: doc/BRIEF.md
# Disk Interface Task-File Register Decoder

This block sits on the device side of a parallel disk interface. It decodes two active-low chip selects (one for the command-block registers, one for the control-block registers), a 3-bit register address and active-low read and write strobes. From them it keeps the task-file registers: features, sector count, sector number, both cylinder bytes, and the drive/head/mode byte. It also keeps a device-control byte and produces a one-cycle command strobe. Reads are returned on a 16-bit data bus together with an output-enable. Only the data port uses all 16 bits. The 8-bit registers return their value in the low byte with zeros above it.

Two devices share the cable. A strap input tells the block whether it is drive 0 or drive 1. Every write to the drive/head register updates the stored drive bit, even when the write is meant for the other device. All other task-file writes, command writes and every read take effect only while the stored drive bit matches the strap. Status, error, drive-address and sector-buffer read data arrive on input ports. Data-port writes leave the block as a strobed word.

The host strobes are sampled by the block clock. In the default configuration a write or read acts once, on the first clock at which its strobe is low.

Top module: `ata_taskfile_top`

## Requirements
- R1: While reset is held and after it is released, every stored register is zero, the drive bit is 0, and `rdata_oe`, `cmd_stb`, `data_wr_stb` and `data_rd_stb` are low.
- R2: With `cs_cmd_n`=0 and `cs_ctl_n`=1, a read from addresses 1 to 7 returns, in that order: the error input, sector count, sector number, cylinder low, cylinder high, drive/head, and the status input. The 8-bit values sit in `rdata[7:0]` with `rdata[15:8]`=0, and `rdata_oe`=1 while `rd_n` is low.
- R3: Address 1 written on the command block loads `tf_features`. It never changes what address 1 returns on a read. A write to address 7 raises `cmd_stb` for exactly one cycle, one clock after the write strobe is first seen, with `cmd_opcode` equal to `wdata[7:0]`.
- R4: With `cs_ctl_n`=0 and `cs_cmd_n`=1:
  - address 6 reads the status input and writes `dev_ctl`;
  - the `dev_ctl` write is accepted whatever the drive bit;
  - address 7 reads `drv_addr_in`;
  - addresses 0 to 5 leave `rdata_oe` low.
- R5: When both selects are high or both are low, no register changes on a write and `rdata_oe` stays low on a read. Whenever `rdata_oe` is low, `rdata` is zero.
- R6: A read of the drive/head register returns bit 7 = 1, bit 6 = mode, bit 5 = 1, bit 4 = drive bit and bits 3:0 = head. Bits 7 and 5 read as 1 whatever was written.
- R7: Every drive/head write loads the drive bit from `wdata[4]`. While the drive bit differs from `strap_drv1`, every read leaves `rdata_oe` low and `data_rd_stb` low.
- R8: While the drive bit differs from `strap_drv1`, writes to features, count, sector, cylinder bytes, command and data are ignored: no `tf_*` change, no `cmd_stb`, no `data_wr_stb`. A drive/head write whose `wdata[4]` differs from the strap leaves head and mode unchanged.
- R9: A write strobe held low for several cycles acts once: a single `cmd_stb` pulse and a single register load.
- R10: An address 0 read returns the 16-bit `data_in` with `data_rd_stb` high in the first read cycle. An address 0 write raises `data_wr_stb` for one cycle, one clock later, with `data_wr_word` equal to `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_drv1 | input | 1 | Strap: 0 = this device is drive 0, 1 = drive 1 |
| cs_cmd_n | input | 1 | Command-block chip select, active low |
| cs_ctl_n | input | 1 | Control-block chip select, active low |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data, zero when not enabled |
| rdata_oe | output | 1 | Read data output-enable |
| status_in | input | 8 | Status byte from the execution engine |
| error_in | input | 8 | Error byte from the execution engine |
| drv_addr_in | input | 8 | Drive-address byte |
| data_in | input | 16 | Sector buffer read word |
| data_rd_stb | output | 1 | Data-port read acknowledge |
| data_wr_stb | output | 1 | Data-port write pulse |
| data_wr_word | output | 16 | Word captured by the last data write |
| cmd_stb | output | 1 | One-cycle command pulse |
| cmd_opcode | output | 8 | Command opcode |
| tf_features | output | 8 | Features register |
| tf_count | output | 8 | Sector count register |
| tf_sector | output | 8 | Sector number / address byte 0 |
| tf_cyl_lo | output | 8 | Cylinder low / address byte 1 |
| tf_cyl_hi | output | 8 | Cylinder high / address byte 2 |
| tf_head | output | 4 | Head / address bits 27:24 |
| tf_lba_mode | output | 1 | Linear addressing mode bit |
| tf_drv | output | 1 | Stored drive-select bit |
| dev_ctl | output | 8 | Device control register |

## Verification
The bench builds the block with its defaults: 16-bit data, 8-bit registers, a 4-bit head field and edge-qualified strobes, with the strap tied to drive 0. The edge qualification makes single-pulse behaviour under long strobes observable (R9). The tie to drive 0 lets the bench move the device in and out of selection just by writing the drive bit, which reaches both the foreign-write and the silent-read cases. The level-sensitive strobe variant and a drive-1 strap are not exercised.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_ERRFEAT,
      SEL_COUNT,
      SEL_SECTOR,
      SEL_CYLLO,
      SEL_CYLHI,
      SEL_DRVHEAD,
      SEL_STATCMD,
      SEL_ALTCTL,
      SEL_DRVADDR
   } tf_sel_e;

   localparam int DH_DRV_BIT  = 4;
   localparam int DH_MODE_BIT = 6;
   localparam int DH_ONE_HI   = 7;
   localparam int DH_ONE_LO   = 5;
   localparam int N_PLAIN     = 5;

   // plain byte registers in storage order
   function automatic tf_sel_e plain_sel(input int idx);
      case (idx)
         0:       return SEL_ERRFEAT;
         1:       return SEL_COUNT;
         2:       return SEL_SECTOR;
         3:       return SEL_CYLLO;
         default: return SEL_CYLHI;
      endcase
   endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
   import ata_tf_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              cs_cmd_n,
   input  logic              cs_ctl_n,
   input  logic [ADDR_W-1:0] addr,
   output tf_sel_e           sel
);

   generate
      if (ADDR_W != 3) begin : g_bad_addr
         $error("ata_tf_decode: ADDR_W must be 3");
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if (!cs_cmd_n && cs_ctl_n) begin
         case (addr)
            3'd0:    sel = SEL_DATA;
            3'd1:    sel = SEL_ERRFEAT;
            3'd2:    sel = SEL_COUNT;
            3'd3:    sel = SEL_SECTOR;
            3'd4:    sel = SEL_CYLLO;
            3'd5:    sel = SEL_CYLHI;
            3'd6:    sel = SEL_DRVHEAD;
            default: sel = SEL_STATCMD;
         endcase
      end else if (cs_cmd_n && !cs_ctl_n) begin
         if (addr == 3'd6)      sel = SEL_ALTCTL;
         else if (addr == 3'd7) sel = SEL_DRVADDR;
      end
   end

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
   import ata_tf_pkg::*;
#(
   parameter int REG_W  = 8,
   parameter int HEAD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap,
   input  logic              wr_fire,
   input  tf_sel_e           sel,
   input  logic [REG_W-1:0]  wbyte,
   output logic [REG_W-1:0]  features,
   output logic [REG_W-1:0]  count,
   output logic [REG_W-1:0]  sector,
   output logic [REG_W-1:0]  cyl_lo,
   output logic [REG_W-1:0]  cyl_hi,
   output logic [HEAD_W-1:0] head,
   output logic              mode,
   output logic              drv,
   output logic [REG_W-1:0]  dev_ctl,
   output logic              selected
);

   generate
      if (REG_W < 8) begin : g_bad_reg
         $error("ata_tf_regs: REG_W must be at least 8");
      end
      if (HEAD_W < 1 || HEAD_W > 4) begin : g_bad_head
         $error("ata_tf_regs: HEAD_W must be 1 to 4");
      end
   endgenerate

   logic [N_PLAIN-1:0][REG_W-1:0] plain_q;
   logic [HEAD_W-1:0]             head_q;
   logic                          mode_q;
   logic                          drv_q;
   logic [REG_W-1:0]              ctl_q;

   assign selected = (drv_q == strap);

   for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (wr_fire && sel == plain_sel(i) && selected)
            q <= wbyte;
      end
      assign plain_q[i] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         mode_q <= 1'b0;
         drv_q  <= 1'b0;
      end else if (wr_fire && sel == SEL_DRVHEAD) begin
         drv_q <= wbyte[DH_DRV_BIT];
         if (wbyte[DH_DRV_BIT] == strap) begin
            head_q <= wbyte[HEAD_W-1:0];
            mode_q <= wbyte[DH_MODE_BIT];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr_fire && sel == SEL_ALTCTL)
         ctl_q <= wbyte;
   end

   assign features = plain_q[0];
   assign count    = plain_q[1];
   assign sector   = plain_q[2];
   assign cyl_lo   = plain_q[3];
   assign cyl_hi   = plain_q[4];
   assign head     = head_q;
   assign mode     = mode_q;
   assign drv      = drv_q;
   assign dev_ctl  = ctl_q;

   AST_FOREIGN_DH_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && sel == SEL_DRVHEAD && wbyte[DH_DRV_BIT] != strap)
      |=> ($stable(head_q) && $stable(mode_q))); // R8
   AST_DRV_FOLLOWS_DH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && sel == SEL_DRVHEAD) |=> (drv_q == $past(wbyte[DH_DRV_BIT]))); // R7
   AST_UNSEL_FEATURES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && sel == SEL_ERRFEAT && !selected) |=> $stable(features)); // R8

endmodule

// File: rtl/ata_taskfile_top.sv
module ata_taskfile_top
   import ata_tf_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int REG_W       = 8,
   parameter int ADDR_W      = 3,
   parameter int HEAD_W      = 4,
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_drv1,
   input  logic              cs_cmd_n,
   input  logic              cs_ctl_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   input  logic [REG_W-1:0]  status_in,
   input  logic [REG_W-1:0]  error_in,
   input  logic [REG_W-1:0]  drv_addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              data_rd_stb,
   output logic              data_wr_stb,
   output logic [DATA_W-1:0] data_wr_word,
   output logic              cmd_stb,
   output logic [REG_W-1:0]  cmd_opcode,
   output logic [REG_W-1:0]  tf_features,
   output logic [REG_W-1:0]  tf_count,
   output logic [REG_W-1:0]  tf_sector,
   output logic [REG_W-1:0]  tf_cyl_lo,
   output logic [REG_W-1:0]  tf_cyl_hi,
   output logic [HEAD_W-1:0] tf_head,
   output logic              tf_lba_mode,
   output logic              tf_drv,
   output logic [REG_W-1:0]  dev_ctl
);

   localparam int PAD_W = DATA_W - REG_W;

   generate
      if (DATA_W <= REG_W) begin : g_bad_data
         $error("ata_taskfile_top: DATA_W must exceed REG_W");
      end
   endgenerate

   tf_sel_e          sel;
   logic             wr_fire;
   logic             rd_fire;
   logic             selected;
   logic [REG_W-1:0] wbyte;

   assign wbyte = wdata[REG_W-1:0];

   // strobe qualification variant
   generate
      if (EDGE_DETECT) begin : g_edge
         logic wr_q, rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_q <= 1'b1;
               rd_q <= 1'b1;
            end else begin
               wr_q <= wr_n;
               rd_q <= rd_n;
            end
         end
         assign wr_fire = !wr_n && wr_q;
         assign rd_fire = !rd_n && rd_q;

         AST_CMD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_stb |=> !cmd_stb); // R9
      end else begin : g_level
         assign wr_fire = !wr_n;
         assign rd_fire = !rd_n;
      end
   endgenerate

   ata_tf_decode #(.ADDR_W(ADDR_W)) u_decode (
      .cs_cmd_n (cs_cmd_n),
      .cs_ctl_n (cs_ctl_n),
      .addr     (addr),
      .sel      (sel)
   );

   ata_tf_regs #(.REG_W(REG_W), .HEAD_W(HEAD_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap    (strap_drv1),
      .wr_fire  (wr_fire),
      .sel      (sel),
      .wbyte    (wbyte),
      .features (tf_features),
      .count    (tf_count),
      .sector   (tf_sector),
      .cyl_lo   (tf_cyl_lo),
      .cyl_hi   (tf_cyl_hi),
      .head     (tf_head),
      .mode     (tf_lba_mode),
      .drv      (tf_drv),
      .dev_ctl  (dev_ctl),
      .selected (selected)
   );

   // command and data-port write pulses
   logic              cmd_stb_q, dwr_stb_q;
   logic [REG_W-1:0]  cmd_op_q;
   logic [DATA_W-1:0] dwr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_stb_q <= 1'b0;
         cmd_op_q  <= '0;
         dwr_stb_q <= 1'b0;
         dwr_q     <= '0;
      end else begin
         cmd_stb_q <= wr_fire && sel == SEL_STATCMD && selected;
         dwr_stb_q <= wr_fire && sel == SEL_DATA && selected;
         if (wr_fire && sel == SEL_STATCMD && selected) cmd_op_q <= wbyte;
         if (wr_fire && sel == SEL_DATA && selected)    dwr_q    <= wdata;
      end
   end

   assign cmd_stb      = cmd_stb_q;
   assign cmd_opcode   = cmd_op_q;
   assign data_wr_stb  = dwr_stb_q;
   assign data_wr_word = dwr_q;

   // read path
   logic [REG_W-1:0]  dh_byte;
   logic [REG_W-1:0]  rd_byte;
   logic              rd_is_word;
   logic              rd_valid;

   always_comb begin
      dh_byte                = '0;
      dh_byte[DH_ONE_HI]     = 1'b1;
      dh_byte[DH_ONE_LO]     = 1'b1;
      dh_byte[DH_MODE_BIT]   = tf_lba_mode;
      dh_byte[DH_DRV_BIT]    = tf_drv;
      dh_byte[HEAD_W-1:0]    = tf_head;
   end

   always_comb begin
      rd_byte    = '0;
      rd_is_word = 1'b0;
      rd_valid   = 1'b1;
      case (sel)
         SEL_DATA:    rd_is_word = 1'b1;
         SEL_ERRFEAT: rd_byte = error_in;
         SEL_COUNT:   rd_byte = tf_count;
         SEL_SECTOR:  rd_byte = tf_sector;
         SEL_CYLLO:   rd_byte = tf_cyl_lo;
         SEL_CYLHI:   rd_byte = tf_cyl_hi;
         SEL_DRVHEAD: rd_byte = dh_byte;
         SEL_STATCMD: rd_byte = status_in;
         SEL_ALTCTL:  rd_byte = status_in;
         SEL_DRVADDR: rd_byte = drv_addr_in;
         default:     rd_valid = 1'b0;
      endcase
   end

   assign rdata_oe    = !rd_n && rd_valid && selected;
   assign rdata       = !rdata_oe ? '0 :
                        rd_is_word ? data_in : {{PAD_W{1'b0}}, rd_byte};
   assign data_rd_stb = rd_fire && sel == SEL_DATA && selected;

   AST_NO_DRIVE_BAD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_cmd_n && !cs_ctl_n) |-> !rdata_oe); // R5
   AST_OE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> !rd_n); // R2
   AST_CMD_FROM_HOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> $past(!wr_n && !cs_cmd_n && cs_ctl_n && addr == 3'd7)); // R3
   AST_CMD_ONLY_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> (tf_drv == strap_drv1)); // R8

endmodule

// File: tb/tb_ata_taskfile_top.sv
module tb_ata_taskfile_top;

   localparam int CLK_PERIOD = 10;
   localparam bit STRAP      = 1'b0;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs_cmd_n, cs_ctl_n, rd_n, wr_n;
   logic [2:0]  addr;
   logic [15:0] wdata, rdata, data_in, data_wr_word;
   logic        rdata_oe, data_rd_stb, data_wr_stb, cmd_stb;
   logic [7:0]  status_in, error_in, drv_addr_in, cmd_opcode;
   logic [7:0]  tf_features, tf_count, tf_sector, tf_cyl_lo, tf_cyl_hi, dev_ctl;
   logic [3:0]  tf_head;
   logic        tf_lba_mode, tf_drv;

   always #(CLK_PERIOD/2) clk = ~clk;

   ata_taskfile_top dut (
      .clk(clk), .rst_n(rst_n), .strap_drv1(STRAP),
      .cs_cmd_n(cs_cmd_n), .cs_ctl_n(cs_ctl_n), .addr(addr),
      .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe),
      .status_in(status_in), .error_in(error_in), .drv_addr_in(drv_addr_in),
      .data_in(data_in), .data_rd_stb(data_rd_stb),
      .data_wr_stb(data_wr_stb), .data_wr_word(data_wr_word),
      .cmd_stb(cmd_stb), .cmd_opcode(cmd_opcode),
      .tf_features(tf_features), .tf_count(tf_count), .tf_sector(tf_sector),
      .tf_cyl_lo(tf_cyl_lo), .tf_cyl_hi(tf_cyl_hi), .tf_head(tf_head),
      .tf_lba_mode(tf_lba_mode), .tf_drv(tf_drv), .dev_ctl(dev_ctl)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   // behavioural reference state
   int m_feat, m_cnt, m_sec, m_cl, m_ch, m_head, m_mode, m_drv, m_ctl;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare_state(input string req);
      chk(req, "features", 32'(tf_features), m_feat);
      chk(req, "count",    32'(tf_count),    m_cnt);
      chk(req, "sector",   32'(tf_sector),   m_sec);
      chk(req, "cyl_lo",   32'(tf_cyl_lo),   m_cl);
      chk(req, "cyl_hi",   32'(tf_cyl_hi),   m_ch);
      chk(req, "head",     32'(tf_head),     m_head);
      chk(req, "mode",     32'(tf_lba_mode), m_mode);
      chk(req, "drv",      32'(tf_drv),      m_drv);
      chk(req, "dev_ctl",  32'(dev_ctl),     m_ctl);
   endtask

   task automatic model_write(input bit ccmd, input bit cctl, input int a, input int d);
      bit is_sel;
      is_sel = (m_drv == int'(STRAP));
      if (ccmd && !cctl) begin
         case (a)
            1: if (is_sel) m_feat = d & 255;
            2: if (is_sel) m_cnt  = d & 255;
            3: if (is_sel) m_sec  = d & 255;
            4: if (is_sel) m_cl   = d & 255;
            5: if (is_sel) m_ch   = d & 255;
            6: begin
               m_drv = (d >> 4) & 1;
               if (m_drv == int'(STRAP)) begin
                  m_head = d & 15;
                  m_mode = (d >> 6) & 1;
               end
            end
            default: ;
         endcase
      end else if (!ccmd && cctl && a == 6) begin
         m_ctl = d & 255;
      end
   endtask

   task automatic model_read(input bit ccmd, input bit cctl, input int a,
                             output bit oe, output int val);
      oe  = 0;
      val = 0;
      if (m_drv != int'(STRAP)) return;
      if (ccmd && !cctl) begin
         oe = 1;
         case (a)
            0: val = int'(data_in);
            1: val = int'(error_in);
            2: val = m_cnt;
            3: val = m_sec;
            4: val = m_cl;
            5: val = m_ch;
            6: val = 8'hA0 | (m_mode << 6) | (m_drv << 4) | m_head;
            default: val = int'(status_in);
         endcase
      end else if (!ccmd && cctl && a == 6) begin
         oe = 1; val = int'(status_in);
      end else if (!ccmd && cctl && a == 7) begin
         oe = 1; val = int'(drv_addr_in);
      end
   endtask

   // ccmd / cctl are 1 when the select is asserted
   task automatic host_write(input bit ccmd, input bit cctl, input int a,
                             input int d, input int hold, input string req);
      bit exp_cmd, exp_dw, is_sel;
      @(negedge clk);
      is_sel  = (m_drv == int'(STRAP));
      exp_cmd = ccmd && !cctl && a == 7 && is_sel;
      exp_dw  = ccmd && !cctl && a == 0 && is_sel;
      cs_cmd_n = !ccmd; cs_ctl_n = !cctl; addr = 3'(a);
      wdata = 16'(d); wr_n = 1'b0;
      @(negedge clk);
      model_write(ccmd, cctl, a, d);
      compare_state(req);
      chk(req, "cmd_stb", 32'(cmd_stb), 32'(exp_cmd));
      if (exp_cmd) chk(req, "cmd_opcode", 32'(cmd_opcode), d & 255);
      chk(req, "data_wr_stb", 32'(data_wr_stb), 32'(exp_dw));
      if (exp_dw) chk(req, "data_wr_word", 32'(data_wr_word), d & 16'hFFFF);
      for (int k = 1; k < hold; k++) begin
         @(negedge clk);
         chk(req, "cmd_stb held", 32'(cmd_stb), 0);
         chk(req, "data_wr_stb held", 32'(data_wr_stb), 0);
         compare_state(req);
      end
      wr_n = 1'b1; cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
   endtask

   task automatic host_read(input bit ccmd, input bit cctl, input int a, input string req);
      bit exp_oe;
      int exp_val;
      @(negedge clk);
      cs_cmd_n = !ccmd; cs_ctl_n = !cctl; addr = 3'(a); rd_n = 1'b0;
      #(CLK_PERIOD/4);
      model_read(ccmd, cctl, a, exp_oe, exp_val);
      chk(req, "rdata_oe", 32'(rdata_oe), 32'(exp_oe));
      chk(req, "rdata", 32'(rdata), exp_oe ? exp_val : 0);
      chk(req, "data_rd_stb", 32'(data_rd_stb), 32'(exp_oe && ccmd && !cctl && a == 0));
      @(negedge clk);
      rd_n = 1'b1; cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; cs_cmd_n = 1'b1; cs_ctl_n = 1'b1; addr = '0;
      rd_n = 1'b1; wr_n = 1'b1; wdata = '0;
      status_in = 8'h50; error_in = 8'h04; drv_addr_in = 8'hC2; data_in = 16'hBEEF;
      m_feat = 0; m_cnt = 0; m_sec = 0; m_cl = 0; m_ch = 0;
      m_head = 0; m_mode = 0; m_drv = 0; m_ctl = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      compare_state("R1");
      chk("R1", "rdata_oe", 32'(rdata_oe), 0);
      chk("R1", "cmd_stb", 32'(cmd_stb), 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare_state("R1");
      chk("R1", "data_wr_stb", 32'(data_wr_stb), 0);
      chk("R1", "data_rd_stb", 32'(data_rd_stb), 0);

      // task-file loads and read-back
      host_write(1, 0, 1, 8'h5A, 1, "R3");
      host_write(1, 0, 2, 8'h10, 1, "R2");
      host_write(1, 0, 3, 8'h01, 1, "R2");
      host_write(1, 0, 4, 8'h34, 1, "R2");
      host_write(1, 0, 5, 8'h12, 1, "R2");
      host_write(1, 0, 6, 8'h03, 1, "R6");
      host_read (1, 0, 6, "R6");
      host_write(1, 0, 6, 8'h4F, 1, "R6");
      host_read (1, 0, 6, "R6");
      for (int a = 1; a < 8; a++) host_read(1, 0, a, "R2");
      host_read (1, 0, 1, "R3");
      host_read (1, 0, 0, "R10");
      data_in = 16'h0F0F;
      host_read (1, 0, 0, "R10");

      // command and data writes
      host_write(1, 0, 7, 8'h20, 3, "R3");
      host_write(1, 0, 0, 16'h1234, 2, "R10");

      // control block
      status_in = 8'h58;
      host_read (0, 1, 6, "R4");
      host_read (0, 1, 7, "R4");
      for (int a = 0; a < 6; a++) host_read(0, 1, a, "R4");
      host_write(0, 1, 6, 8'h02, 1, "R4");

      // invalid select combinations
      host_write(1, 1, 2, 8'h77, 1, "R5");
      host_read (1, 1, 2, "R5");
      host_write(0, 0, 3, 8'h66, 1, "R5");
      host_read (0, 0, 7, "R5");

      // switch selection to the other drive
      host_write(1, 0, 6, 8'h1B, 1, "R8");
      host_read (1, 0, 2, "R7");
      host_read (1, 0, 7, "R7");
      host_read (1, 0, 0, "R7");
      host_read (0, 1, 6, "R7");
      host_write(1, 0, 1, 8'h99, 1, "R8");
      host_write(1, 0, 7, 8'hC8, 1, "R8");
      host_write(1, 0, 0, 16'hAAAA, 1, "R8");
      host_write(0, 1, 6, 8'h04, 1, "R4");

      // back to this drive
      host_write(1, 0, 6, 8'h45, 1, "R7");
      host_read (1, 0, 6, "R6");
      host_write(1, 0, 7, 8'h30, 1, "R3");

      // long strobe: single action
      host_write(1, 0, 7, 8'h40, 4, "R9");
      host_write(1, 0, 2, 8'h81, 4, "R9");
      host_read (1, 0, 2, "R9");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog R1: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule